// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slow bit clock from a fast system clock when the wanted ratio is not a whole number. The output is built from a repeating frame of steps, and a toggle of the output level ends each step. A step lasts either a base length of N system cycles (short) or N+1 cycles (long). The first S positions of a frame are short and the remaining F−S are long, so the mean step length is (S·N + (F−S)·(N+1))/F cycles. For example, N=9, F=4, S=1 gives a mean of 9.75 cycles. The cost is jitter: from one step to the next, the step length moves by one system-clock period.

With S equal to F, every step is N cycles long. The block is then a plain integer divider by 2N with an exactly 50% duty cycle. A one-cycle step strobe runs alongside the output level for logic that uses clock enables, and a frame strobe marks the end of each frame. The settings can change at any time, but they take effect only at reset or at a frame boundary.

Top module: `fracdiv_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), `div_clk`, `step_tick` and `frame_start` are 0. The settings on the inputs are captured. The first enabled cycle after reset begins step position 0 of a fresh frame, with the step counter at zero.
- R2: Frame position i, counted from 0, lasts N enabled cycles when i < S and N+1 enabled cycles otherwise. After position F−1 the position returns to 0.
- R3: At every step boundary, `div_clk` inverts and `step_tick` is 1, both in the same cycle. `step_tick` is 1 for a single cycle only, and `div_clk` changes at no other time.
- R4: `frame_start` is 1 only together with the `step_tick` that ends position F−1. It marks the point where a new frame begins.
- R5: Over any whole number of frames, the total number of cycles equals the frame count times S·N + (F−S)·(N+1). The mean step length is therefore (S·N + (F−S)·(N+1))/F.
- R6: With S = F, the high time and the low time of `div_clk` are both exactly N cycles (even ratio 2N, 50% duty).
- R7: Changes to `base_len`, `frame_len` and `short_cnt` have no effect on steps of the current frame. They are adopted only at reset or when the frame ends.
- R8: While `en` is 0, the step counter and the frame position hold, `div_clk` keeps its level, and neither strobe is raised.
- R9: Settings are clamped when they are adopted. A base length below 2 is used as 2. A frame length of 0 is used as 1, and one above 16 is used as 16. A short count above the (clamped) frame length is used as the frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; when low the block holds its state |
| base_len | input | 16 | Base step length N in system cycles |
| frame_len | input | 5 | Number of steps per frame F |
| short_cnt | input | 5 | Number of short steps S at the start of each frame |
| div_clk | output | 1 | Divided clock level, toggles at each step boundary |
| step_tick | output | 1 | One-cycle strobe at each step boundary |
| frame_start | output | 1 | One-cycle strobe at the boundary that starts a new frame |

## Verification
A corrupted frame position shows up as a wrong short/long order. It becomes visible within one frame, as an interval between strobes that is off by one cycle or as a frame strobe on the wrong step. A step counter that skips or sticks lengthens or shortens the very next interval between toggles. The bench measures every interval in cycles against the programmed pattern, sums the intervals over whole frames, and compares the high and low times in the integer case. A settings register that loads at the wrong moment changes the length of a step that belongs to the old frame. That error is caught at the first boundary after the change.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    parameter int unsigned LEN_W     = 16;
    parameter int unsigned FRM_W     = 5;
    parameter int unsigned MAX_FRAME = 16;
    parameter int unsigned MIN_LEN   = 2;
    localparam int unsigned IDX_W    = $clog2(MAX_FRAME);

    typedef struct packed {
        logic [LEN_W-1:0] n;
        logic [FRM_W-1:0] f;
        logic [FRM_W-1:0] s;
    } div_cfg_t;

    function automatic div_cfg_t clamp_cfg(input logic [LEN_W-1:0] n_in,
                                           input logic [FRM_W-1:0] f_in,
                                           input logic [FRM_W-1:0] s_in);
        div_cfg_t c;
        c.n = (n_in < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : n_in;
        if (f_in == '0)
            c.f = FRM_W'(1);
        else if (f_in > FRM_W'(MAX_FRAME))
            c.f = FRM_W'(MAX_FRAME);
        else
            c.f = f_in;
        c.s = (s_in > c.f) ? c.f : s_in;
        return c;
    endfunction

endpackage

// File: rtl/fracdiv_cfg_hold.sv
module fracdiv_cfg_hold
    import fracdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [LEN_W-1:0]     n_in,
    input  logic [FRM_W-1:0]     f_in,
    input  logic [FRM_W-1:0]     s_in,
    output div_cfg_t             cfg
);
    // Settings are adopted at reset and at each frame boundary only.
    always_ff @(posedge clk) begin
        if (rst || load)
            cfg <= clamp_cfg(n_in, f_in, s_in);
    end
endmodule

// File: rtl/fracdiv_seq.sv
module fracdiv_seq
    import fracdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  div_cfg_t         cfg,
    output logic [LEN_W-1:0] end_val,
    output logic             last_step
);
    logic [IDX_W-1:0] idx;
    logic [FRM_W-1:0] idx_ext;

    assign idx_ext   = FRM_W'(idx);
    assign last_step = (idx_ext == cfg.f - FRM_W'(1));
    // Short steps sit at the front of the frame.
    assign end_val   = (idx_ext < cfg.s) ? (cfg.n - LEN_W'(1)) : cfg.n;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (advance)
            idx <= last_step ? '0 : idx + IDX_W'(1);
    end
endmodule

// File: rtl/fracdiv_step_ctr.sv
module fracdiv_step_ctr
    import fracdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LEN_W-1:0] end_val,
    output logic             at_end
);
    logic [LEN_W-1:0] cnt;

    assign at_end = (cnt == end_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= at_end ? '0 : cnt + LEN_W'(1);
    end
endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
    import fracdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LEN_W-1:0] base_len,
    input  logic [FRM_W-1:0] frame_len,
    input  logic [FRM_W-1:0] short_cnt,
    output logic             div_clk,
    output logic             step_tick,
    output logic             frame_start
);
    div_cfg_t         cfg;
    logic [LEN_W-1:0] end_val;
    logic             at_end;
    logic             last_step;
    logic             boundary;
    logic             frame_wrap;

    assign boundary   = en && at_end;
    assign frame_wrap = boundary && last_step;

    fracdiv_cfg_hold u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (frame_wrap),
        .n_in (base_len),
        .f_in (frame_len),
        .s_in (short_cnt),
        .cfg  (cfg)
    );

    fracdiv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .advance   (boundary),
        .cfg       (cfg),
        .end_val   (end_val),
        .last_step (last_step)
    );

    fracdiv_step_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .end_val (end_val),
        .at_end  (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_clk     <= 1'b0;
            step_tick   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            step_tick   <= boundary;
            frame_start <= frame_wrap;
            if (boundary)
                div_clk <= ~div_clk;
        end
    end
endmodule

// File: rtl/fracdiv_checker.sv
module fracdiv_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic div_clk,
    input logic step_tick,
    input logic frame_start
);
    // R3
    toggle_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (div_clk != $past(div_clk)) == step_tick);

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> !step_tick);

    // R4
    frame_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> step_tick);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!step_tick && !frame_start && $stable(div_clk)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!div_clk && !step_tick && !frame_start));
endmodule

bind fracdiv_top fracdiv_checker u_fracdiv_checker (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .div_clk     (div_clk),
    .step_tick   (step_tick),
    .frame_start (frame_start)
);

// File: tb/fracdiv_top_test.sv
`timescale 1ns/1ps
module fracdiv_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic [15:0] base_len  = 16'd9;
    logic [4:0]  frame_len = 5'd4;
    logic [4:0]  short_cnt = 5'd1;
    logic        div_clk, step_tick, frame_start;

    int n_chk  = 0;
    int n_fail = 0;
    bit hung   = 1'b0;

    always #5 clk = ~clk;

    fracdiv_top uut (
        .clk(clk), .rst(rst), .en(en),
        .base_len(base_len), .frame_len(frame_len), .short_cnt(short_cnt),
        .div_clk(div_clk), .step_tick(step_tick), .frame_start(frame_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int n, input int f, input int s);
        base_len = 16'(n); frame_len = 5'(f); short_cnt = 5'(s);
        en = 1'b1; rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // Counts edges until the next step_tick; also reports frame_start.
    task automatic wait_tick(output int edges, output bit fr);
        edges = 0; fr = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk); #1;
            edges++;
            if (step_tick) begin
                fr = frame_start;
                return;
            end
        end
        hung = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check(div_clk == 1'b0, "R1 div_clk low", int'(div_clk), 0);
        check(step_tick == 1'b0 && frame_start == 1'b0, "R1 strobes low",
              int'(step_tick) + int'(frame_start), 0);
        rst = 1'b0;
    endtask

    task automatic t_pattern_and_average();
        int e; bit fr; int total;
        do_reset(9, 4, 1);
        total = 0;
        for (int i = 0; i < 12; i++) begin
            wait_tick(e, fr);
            total += e;
            check(e == (((i % 4) < 1) ? 9 : 10), "R2 step length", e, ((i % 4) < 1) ? 9 : 10);
            check(fr == ((i % 4) == 3), "R4 frame strobe", int'(fr), int'((i % 4) == 3));
        end
        check(total == 3 * (1 * 9 + 3 * 10), "R5 three-frame total", total, 117);
    endtask

    task automatic t_mixed_pattern();
        int e; bit fr; int total; int expv;
        do_reset(5, 7, 3);
        total = 0;
        for (int i = 0; i < 14; i++) begin
            wait_tick(e, fr);
            total += e;
            expv = ((i % 7) < 3) ? 5 : 6;
            check(e == expv, "R2 mixed step length", e, expv);
        end
        check(total == 2 * (3 * 5 + 4 * 6), "R5 two-frame total", total, 78);
    endtask

    task automatic t_all_long();
        int e; bit fr;
        do_reset(3, 3, 0);
        for (int i = 0; i < 6; i++) begin
            wait_tick(e, fr);
            check(e == 4, "R2 all long steps", e, 4);
        end
    endtask

    task automatic t_even_duty();
        int e; bit fr; int hi; int lo;
        do_reset(5, 1, 1);
        wait_tick(e, fr);
        check(div_clk == 1'b1, "R6 rises at first boundary", int'(div_clk), 1);
        hi = 0;
        for (int k = 0; k < 100 && div_clk; k++) begin @(posedge clk); #1; hi++; end
        lo = 0;
        for (int k = 0; k < 100 && !div_clk; k++) begin @(posedge clk); #1; lo++; end
        check(hi == 5, "R6 high time", hi, 5);
        check(lo == 5, "R6 low time", lo, 5);
    endtask

    task automatic t_midframe_change();
        int e; bit fr;
        do_reset(9, 4, 1);
        wait_tick(e, fr);
        check(e == 9, "R7 first step", e, 9);
        base_len = 16'd4; frame_len = 5'd2; short_cnt = 5'd2;
        for (int i = 0; i < 3; i++) begin
            wait_tick(e, fr);
            check(e == 10, "R7 old frame kept", e, 10);
        end
        check(fr == 1'b1, "R7 frame end", int'(fr), 1);
        for (int i = 0; i < 3; i++) begin
            wait_tick(e, fr);
            check(e == 4, "R7 new settings", e, 4);
        end
    endtask

    task automatic t_enable_hold();
        int edges; bit lvl;
        do_reset(6, 1, 1);
        @(posedge clk); @(posedge clk); #1;
        en = 1'b0;
        lvl = div_clk;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            check(!step_tick && div_clk == lvl, "R8 hold", int'(step_tick), 0);
        end
        en = 1'b1;
        edges = 7;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk); #1; edges++;
            if (step_tick) break;
        end
        check(edges == 11, "R8 resumed count", edges, 11);
    endtask

    task automatic t_clamp();
        int e; bit fr;
        do_reset(1, 0, 7);
        for (int i = 0; i < 4; i++) begin
            wait_tick(e, fr);
            check(e == 2, "R9 min length", e, 2);
            check(fr == 1'b1, "R9 frame of one", int'(fr), 1);
        end
        do_reset(3, 20, 20);
        for (int i = 0; i < 16; i++) begin
            wait_tick(e, fr);
            check(e == 3, "R9 capped short", e, 3);
            check(fr == (i == 15), "R9 frame capped at 16", int'(fr), int'(i == 15));
        end
    endtask

    initial begin
        t_reset();
        t_pattern_and_average();
        t_mixed_pattern();
        t_all_long();
        t_even_duty();
        t_midframe_change();
        t_enable_hold();
        t_clamp();
        if (hung) check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule